// File: doc/BRIEF.md
# Decimal Floating-Point BCD Packer

This block turns a signed BCD fixed-point number into a 15-digit decimal floating-point word. The caller presents a sign bit, a group of integer BCD digits and a group of fraction BCD digits, then pulses `start_i`. The digits are joined into one string with the radix point after the integer group. A sequential normalizer moves that string left by one BCD digit per clock, counting the exponent down, until the leading digit is nonzero. The block then emits a packed word. The word holds a sign digit, a two-digit exponent in excess-49 form, and a twelve-digit fraction mantissa in which the radix point stands just left of the first digit.

Two exponent codes are kept out of the finite range. Code 00 marks zero and code 99 marks infinity. An input whose digits are all zero, or whose magnitude is too small to encode, packs to code 00. An input too large to encode packs to code 99. Each of these three outcomes raises its own flag. Mantissa digits past the twelfth are dropped without rounding. The result stays on the outputs until the next conversion finishes. A `start_i` that arrives while a conversion is under way has no effect.

Top module: `dfp_bcd_packer`

## Requirements
- R1: `word_o` holds the sign digit in bits [59:56] (0 for plus, 1 for minus; bits 59..57 are always 0), the exponent as two BCD digits in [55:48] with the tens digit on top, and the mantissa in [47:0] with its first digit in [47:44]. The value is 0.m x 10^(code-49).
- R2: For a finite nonzero result, the first mantissa digit is nonzero. The true exponent equals the number of integer digits minus the number of leading zero digits in the joined string. A true exponent from -48 to +49 encodes as code 01 to 98.
- R3: The mantissa takes the twelve digits that start at the first nonzero digit. Digits after those twelve are discarded with no rounding. Positions beyond the end of the input string are filled with zero.
- R4: An input with all digits zero gives exponent 00 and mantissa 0, passes the sign through, and raises `zero_o`.
- R5: A true exponent above +49 gives exponent 99 and mantissa 0, passes the sign through, and raises `ovf_o`.
- R6: A true exponent below -48 gives exponent 00 and mantissa 0, passes the sign through, and raises `unf_o`.
- R7: `start_i` is accepted only while `busy_o` is low. `busy_o` is high from the cycle after acceptance until the result is ready. `done_o` is a single-cycle pulse that arrives together with the new `word_o` and flags, and these outputs hold their values until the next `done_o`. After reset, all outputs are 0.
- R8: A `start_i` given while `busy_o` is high is ignored. The result that follows still belongs to the accepted input.
- R9: Counting the accepting clock edge as edge 0, `done_o` rises after edge 1 for an all-zero input, after edge p+1 when the first nonzero digit sits at position p (0 = leftmost), and after edge INT_DIGITS+49 for an underflow.
- R10: At most one of `zero_o`, `ovf_o` and `unf_o` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a conversion (used when idle) |
| sign_i | input | 1 | Sign of the value, 1 for negative |
| int_digits_i | input | 4*INT_DIGITS | Integer BCD digits, most significant on top |
| frac_digits_i | input | 4*FRAC_DIGITS | Fraction BCD digits, first after the point on top |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| word_o | output | 4*(MANT_DIGITS+3) | Packed sign, exponent and mantissa |
| zero_o | output | 1 | Result is an exact zero |
| ovf_o | output | 1 | Result saturated to infinity |
| unf_o | output | 1 | Result flushed to zero because it was too small |

## Verification
The bench builds the packer with 52 integer digits and 52 fraction digits, keeping the default mantissa length of twelve and the bias of 49. With defaults of twelve and twelve, true exponents run only from -11 to +12, so neither saturation nor flush can happen. With 52 and 52, the string can put its first nonzero digit in the overflow band (exponent +50 to +52) or the underflow band (-49 to -51). It can also land exactly on both finite limits, which encode as codes 98 and 01. The longest run of the shift loop, 101 clocks, is exercised as well.

// File: rtl/dfp_pkg.sv
package dfp_pkg;

  // How the finishing scan step classified the digit string
  typedef enum logic [1:0] {
    CLS_NORM  = 2'd0,
    CLS_ZERO  = 2'd1,
    CLS_UNDER = 2'd2
  } dfp_cls_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } dfp_state_e;

  // Highest code of the two-digit exponent field; reserved for infinity
  localparam int CODE_TOP = 99;

endpackage

// File: rtl/dfp_digit_norm.sv
module dfp_digit_norm #(
  parameter int TOT_DIGITS  = 24,
  parameter int MANT_DIGITS = 12,
  parameter int EW          = 8,
  parameter int INIT_EXP    = 12,
  parameter int MIN_EXP     = -48
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_i,
  input  logic                        shift_i,
  input  logic [TOT_DIGITS*4-1:0]     digits_i,
  output logic [MANT_DIGITS*4-1:0]    mant_o,
  output logic signed [EW-1:0]        exp_o,
  output logic                        lead_zero_o,
  output logic                        all_zero_o,
  output logic                        at_floor_o
);

  localparam int SW = TOT_DIGITS * 4;
  localparam int MW = MANT_DIGITS * 4;
  localparam logic signed [EW-1:0] INIT_S  = EW'(INIT_EXP);
  localparam logic signed [EW-1:0] FLOOR_S = EW'(MIN_EXP);
  localparam logic signed [EW-1:0] ONE_S   = EW'(1);

  logic [SW-1:0]        str_q, str_d;
  logic signed [EW-1:0] exp_q, exp_d;
  logic                 en;

  assign en = load_i | shift_i;

  always_comb begin
    str_d = str_q;
    exp_d = exp_q;
    if (load_i) begin
      str_d = digits_i;
      exp_d = INIT_S;
    end else if (shift_i) begin
      str_d = {str_q[SW-5:0], 4'h0};
      exp_d = exp_q - ONE_S;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      str_q <= '0;
      exp_q <= '0;
    end else if (en) begin
      str_q <= str_d;
      exp_q <= exp_d;
    end
  end

  assign mant_o      = str_q[SW-1 -: MW];
  assign exp_o       = exp_q;
  assign lead_zero_o = (str_q[SW-1 -: 4] == 4'h0);
  assign all_zero_o  = ~|str_q;
  assign at_floor_o  = (exp_q == FLOOR_S);

endmodule

// File: rtl/dfp_exp_code.sv
module dfp_exp_code
  import dfp_pkg::*;
#(
  parameter int MANT_DIGITS = 12,
  parameter int EW          = 8,
  parameter int EXP_BIAS    = 49
) (
  input  dfp_cls_e                    cls_i,
  input  logic signed [EW-1:0]        exp_i,
  input  logic [MANT_DIGITS*4-1:0]    mant_i,
  output logic [7:0]                  code_o,
  output logic [MANT_DIGITS*4-1:0]    mant_o,
  output logic                        zero_o,
  output logic                        ovf_o,
  output logic                        unf_o
);

  localparam int EMAX = CODE_TOP - 1 - EXP_BIAS;
  localparam logic signed [EW-1:0] EMAX_S = EW'(EMAX);
  localparam logic signed [EW-1:0] BIAS_S = EW'(EXP_BIAS);

  logic [6:0] bv;
  logic [3:0] tens;
  logic [3:0] units;

  // Biased exponent to two BCD digits by comparing against multiples of ten
  always_comb begin
    bv   = 7'(exp_i + BIAS_S);
    tens = 4'd0;
    for (int k = 1; k < 10; k++) begin
      if (bv >= 7'(k * 10)) tens = 4'(k);
    end
    units = 4'(bv - 7'(tens) * 7'd10);
  end

  always_comb begin
    code_o = 8'h00;
    mant_o = '0;
    zero_o = 1'b0;
    ovf_o  = 1'b0;
    unf_o  = 1'b0;
    unique case (cls_i)
      CLS_ZERO:  zero_o = 1'b1;
      CLS_UNDER: unf_o  = 1'b1;
      default: begin
        if (exp_i > EMAX_S) begin
          ovf_o  = 1'b1;
          code_o = 8'h99;
        end else begin
          code_o = {tens, units};
          mant_o = mant_i;
        end
      end
    endcase
  end

endmodule

// File: rtl/dfp_seq.sv
module dfp_seq
  import dfp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  logic     all_zero_i,
  input  logic     lead_zero_i,
  input  logic     at_floor_i,
  output logic     load_o,
  output logic     shift_o,
  output logic     fin_o,
  output dfp_cls_e cls_o,
  output logic     busy_o
);

  dfp_state_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    load_o  = 1'b0;
    shift_o = 1'b0;
    fin_o   = 1'b0;
    cls_o   = CLS_NORM;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o = 1'b1;
          st_d   = ST_SCAN;
        end
      end
      default: begin
        if (all_zero_i) begin
          fin_o = 1'b1;
          cls_o = CLS_ZERO;
        end else if (!lead_zero_i) begin
          fin_o = 1'b1;
          cls_o = CLS_NORM;
        end else if (at_floor_i) begin
          fin_o = 1'b1;
          cls_o = CLS_UNDER;
        end else begin
          shift_o = 1'b1;
        end
        if (fin_o) st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign busy_o = (st_q == ST_SCAN);

endmodule

// File: rtl/dfp_rst_sync.sv
module dfp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic r1_q, r2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1_q <= 1'b0;
      r2_q <= 1'b0;
    end else begin
      r1_q <= 1'b1;
      r2_q <= r1_q;
    end
  end

  assign rst_n_sync = r2_q;

endmodule

// File: rtl/dfp_bcd_packer.sv
module dfp_bcd_packer
  import dfp_pkg::*;
#(
  parameter int INT_DIGITS  = 12,
  parameter int FRAC_DIGITS = 12,
  parameter int MANT_DIGITS = 12,
  parameter int EXP_BIAS    = 49
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start_i,
  input  logic                           sign_i,
  input  logic [INT_DIGITS*4-1:0]        int_digits_i,
  input  logic [FRAC_DIGITS*4-1:0]       frac_digits_i,
  output logic                           busy_o,
  output logic                           done_o,
  output logic [4*(MANT_DIGITS+3)-1:0]   word_o,
  output logic                           zero_o,
  output logic                           ovf_o,
  output logic                           unf_o
);

  localparam int TOT_DIGITS = INT_DIGITS + FRAC_DIGITS;
  localparam int MW         = MANT_DIGITS * 4;
  localparam int WW         = MW + 12;
  localparam int EW         = $clog2(TOT_DIGITS + 2 * EXP_BIAS + 4) + 1;
  localparam int MIN_EXP    = 1 - EXP_BIAS;

  logic                 rst_ns;
  logic                 load, shift, fin, lead_zero, all_zero, at_floor;
  dfp_cls_e             cls;
  logic [MW-1:0]        mant_raw, mant_fmt;
  logic signed [EW-1:0] exp_cur;
  logic [7:0]           code;
  logic                 f_zero, f_ovf, f_unf;

  logic                 sign_q;
  logic [WW-1:0]        word_q, word_d;
  logic                 zero_q, ovf_q, unf_q, done_q;

  dfp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  dfp_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_ns),
    .start_i     (start_i),
    .all_zero_i  (all_zero),
    .lead_zero_i (lead_zero),
    .at_floor_i  (at_floor),
    .load_o      (load),
    .shift_o     (shift),
    .fin_o       (fin),
    .cls_o       (cls),
    .busy_o      (busy_o)
  );

  dfp_digit_norm #(
    .TOT_DIGITS  (TOT_DIGITS),
    .MANT_DIGITS (MANT_DIGITS),
    .EW          (EW),
    .INIT_EXP    (INT_DIGITS),
    .MIN_EXP     (MIN_EXP)
  ) u_norm (
    .clk         (clk),
    .rst_n       (rst_ns),
    .load_i      (load),
    .shift_i     (shift),
    .digits_i    ({int_digits_i, frac_digits_i}),
    .mant_o      (mant_raw),
    .exp_o       (exp_cur),
    .lead_zero_o (lead_zero),
    .all_zero_o  (all_zero),
    .at_floor_o  (at_floor)
  );

  dfp_exp_code #(
    .MANT_DIGITS (MANT_DIGITS),
    .EW          (EW),
    .EXP_BIAS    (EXP_BIAS)
  ) u_code (
    .cls_i  (cls),
    .exp_i  (exp_cur),
    .mant_i (mant_raw),
    .code_o (code),
    .mant_o (mant_fmt),
    .zero_o (f_zero),
    .ovf_o  (f_ovf),
    .unf_o  (f_unf)
  );

  assign word_d = {3'b000, sign_q, code, mant_fmt};

  // Sign is captured with the digits
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)   sign_q <= 1'b0;
    else if (load) sign_q <= sign_i;
  end

  // Result register, written only when a scan finishes
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      word_q <= '0;
      zero_q <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else if (fin) begin
      word_q <= word_d;
      zero_q <= f_zero;
      ovf_q  <= f_ovf;
      unf_q  <= f_unf;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) done_q <= 1'b0;
    else         done_q <= fin;
  end

  assign word_o = word_q;
  assign zero_o = zero_q;
  assign ovf_o  = ovf_q;
  assign unf_o  = unf_q;
  assign done_o = done_q;

endmodule

// File: rtl/dfp_bcd_packer_chk.sv
module dfp_bcd_packer_chk #(
  parameter int MANT_DIGITS = 12
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         start_i,
  input logic                         busy_o,
  input logic                         done_o,
  input logic [4*(MANT_DIGITS+3)-1:0] word_o,
  input logic                         zero_o,
  input logic                         ovf_o,
  input logic                         unf_o
);

  localparam int MW = MANT_DIGITS * 4;

  logic [3:0]    sdig;
  logic [7:0]    code;
  logic [MW-1:0] mant;

  assign sdig = word_o[MW+11:MW+8];
  assign code = word_o[MW+7:MW];
  assign mant = word_o[MW-1:0];

  p_sign_digit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sdig <= 4'd1);

  p_norm_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !zero_o && !ovf_o && !unf_o) |->
      (mant[MW-1 -: 4] != 4'h0) && (code[7:4] <= 4'd9) && (code[3:0] <= 4'd9)
      && (code != 8'h00) && (code != 8'h99));

  p_zero_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o |-> (code == 8'h00) && (mant == '0));

  p_ovf_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (code == 8'h99) && (mant == '0));

  p_unf_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |-> (code == 8'h00) && (mant == '0));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(word_o));

  p_busy_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({zero_o, ovf_o, unf_o}));

endmodule

bind dfp_bcd_packer dfp_bcd_packer_chk #(
  .MANT_DIGITS (MANT_DIGITS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .word_o  (word_o),
  .zero_o  (zero_o),
  .ovf_o   (ovf_o),
  .unf_o   (unf_o)
);

// File: tb/sim_dfp_bcd_packer.sv
`timescale 1ns/1ps
module sim_dfp_bcd_packer;

  localparam int INT_D  = 52;
  localparam int FRAC_D = 52;
  localparam int MANT_D = 12;
  localparam int TOT    = INT_D + FRAC_D;
  localparam int VW     = TOT * 4;
  localparam int WW     = 4 * (MANT_D + 3);

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start = 1'b0;
  logic                sgn = 1'b0;
  logic [INT_D*4-1:0]  idig = '0;
  logic [FRAC_D*4-1:0] fdig = '0;
  logic                busy, done, zf, of, uf;
  logic [WW-1:0]       word;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dfp_bcd_packer #(
    .INT_DIGITS  (INT_D),
    .FRAC_DIGITS (FRAC_D),
    .MANT_DIGITS (MANT_D),
    .EXP_BIAS    (49)
  ) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start),
    .sign_i        (sgn),
    .int_digits_i  (idig),
    .frac_digits_i (fdig),
    .busy_o        (busy),
    .done_o        (done),
    .word_o        (word),
    .zero_o        (zf),
    .ovf_o         (of),
    .unf_o         (uf)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] dig(input logic [VW-1:0] v, input int i);
    return v[(TOT-1-i)*4 +: 4];
  endfunction

  // First nonzero digit at position p (p == TOT gives all zeros)
  function automatic logic [VW-1:0] make_val(input int p, input bit all9);
    logic [VW-1:0] v = '0;
    for (int i = 0; i < TOT; i++) begin
      logic [3:0] d = 4'h0;
      if (i == p)     d = all9 ? 4'd9 : 4'($urandom % 9 + 1);
      else if (i > p) d = all9 ? 4'd9 : 4'($urandom % 10);
      v[(TOT-1-i)*4 +: 4] = d;
    end
    return v;
  endfunction

  // Expected word, flags {zero,ovf,unf} and latency from the requirements
  task automatic model(input logic [VW-1:0] v, input logic s,
                       output logic [WW-1:0] w, output logic [2:0] f, output int lat);
    int p = TOT;
    int e;
    int b;
    logic [4*MANT_D-1:0] m = '0;
    for (int i = TOT - 1; i >= 0; i--) if (dig(v, i) != 4'h0) p = i;
    if (p == TOT) begin
      w = {3'b000, s, 8'h00, m}; f = 3'b100; lat = 1;
    end else begin
      e = INT_D - p;
      if (e > 49) begin
        w = {3'b000, s, 8'h99, m}; f = 3'b010; lat = p + 1;
      end else if (e < -48) begin
        w = {3'b000, s, 8'h00, m}; f = 3'b001; lat = INT_D + 49;
      end else begin
        b = e + 49;
        for (int j = 0; j < MANT_D; j++)
          m[(MANT_D-1-j)*4 +: 4] = (p + j < TOT) ? dig(v, p + j) : 4'h0;
        w = {3'b000, s, 4'(b / 10), 4'(b % 10), m}; f = 3'b000; lat = p + 1;
      end
    end
  endtask

  task automatic drive(input logic [VW-1:0] v, input logic s);
    idig = v[VW-1 -: INT_D*4];
    fdig = v[FRAC_D*4-1:0];
    sgn  = s;
  endtask

  task automatic run(input logic [VW-1:0] v, input logic s, input string tag);
    logic [WW-1:0] ew;
    logic [2:0]    ef;
    int            el;
    int            k = 0;
    model(v, s, ew, ef, el);
    @(negedge clk);
    drive(v, s);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 busy after start", 64'(busy), 64'd1);
    do begin
      @(negedge clk);
      k++;
    end while (!done && k < 400);
    if (!done) begin
      chk("R7 done never seen", 64'd0, 64'd1);
    end else begin
      chk("R9 latency", 64'(k), 64'(el));
      chk({tag, " word"}, 64'(word), 64'(ew));
      chk({tag, " flags"}, 64'({zf, of, uf}), 64'(ef));
    end
  endtask

  initial begin
    #(8 * 190000);
    n_chk++;
    n_bad++;
    $display("FAIL R7 watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [VW-1:0] va, vb;
    logic [WW-1:0] ew, held;
    logic [2:0]    ef;
    int            el;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 reset word", 64'(word), 64'd0);
    chk("R7 reset status", 64'({busy, done, zf, of, uf}), 64'd0);

    // R4: all zeros, negative sign passes through
    run('0, 1'b1, "R4 zero");
    // R5: exponents +52 and +50 saturate
    run(make_val(0, 1'b0), 1'b0, "R5 ovf e52");
    run(make_val(2, 1'b1), 1'b1, "R5 ovf e50");
    // R2: largest finite, code 98, all nines without rounding (R3)
    run(make_val(3, 1'b1), 1'b0, "R2 R3 max finite");
    // R2/R3: smallest exponent -48 with zero fill past end of string
    run(make_val(100, 1'b0), 1'b1, "R2 R3 min finite");
    // R6: exponents -49 and -51 flush
    run(make_val(101, 1'b0), 1'b1, "R6 unf e-49");
    run(make_val(103, 1'b0), 1'b0, "R6 unf e-51");
    // R3: nines past twelfth digit are dropped
    run(make_val(10, 1'b1), 1'b0, "R3 truncate");

    // R1/R2: 6918.3125 packs to code 53 with mantissa 691831250000
    va = '0;
    va[(TOT-1-48)*4 +: 4] = 4'd6; va[(TOT-1-49)*4 +: 4] = 4'd9;
    va[(TOT-1-50)*4 +: 4] = 4'd1; va[(TOT-1-51)*4 +: 4] = 4'd8;
    va[(TOT-1-52)*4 +: 4] = 4'd3; va[(TOT-1-53)*4 +: 4] = 4'd1;
    va[(TOT-1-54)*4 +: 4] = 4'd2; va[(TOT-1-55)*4 +: 4] = 4'd5;
    run(va, 1'b0, "R1 R2 sample");
    chk("R1 literal layout", 64'(word), 64'({4'h0, 8'h53, 48'h691831250000}));

    // R8: second start while busy is ignored
    va = make_val(20, 1'b0);
    vb = make_val(5, 1'b0);
    model(va, 1'b0, ew, ef, el);
    @(negedge clk);
    drive(va, 1'b0);
    start = 1'b1;
    @(negedge clk);
    drive(vb, 1'b1);
    @(negedge clk);
    start = 1'b0;
    begin
      int k = 0;
      while (!done && k < 400) begin
        @(negedge clk);
        k++;
      end
    end
    chk("R8 ignored start word", 64'(word), 64'(ew));
    chk("R8 ignored start flags", 64'({zf, of, uf}), 64'(ef));

    // R7: result holds while inputs move without start
    held = word;
    for (int i = 0; i < 5; i++) begin
      drive(make_val(i, 1'b0), 1'b1);
      @(negedge clk);
      chk("R7 hold word", 64'(word), 64'(held));
      chk("R7 done low", 64'(done), 64'd0);
    end

    // Random mix over all leading positions, R10 checked through the flag field
    for (int n = 0; n < 260; n++) begin
      int p = int'($urandom % (TOT + 1));
      run(make_val(p, ($urandom % 8) == 0), 1'($urandom % 2), "R2 R10 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule